// File: doc/BRIEF.md
# Keyed Watchdog Timer

This block is a watchdog that counts down on a slow clock and pulses a reset output when software stops servicing it. It sits behind a plain register port with a byte address, write data, a write strobe and combinational read data. Every write that changes behaviour must carry a fixed key value. A write whose key is wrong is ignored.

Software picks a timeout in coarse units. One unit is 512 ticks of the watchdog clock, and the count field is 10 bits wide. Software arms the block with a keyed control write and then reloads the countdown periodically by writing a restart key. If the countdown expires, or software writes the reset key, the block drives a fixed-length reset pulse. The pulse polarity is selectable and the pulse can be gated off the pin. An interrupt output can mirror the pulse. A sticky status register records which cause fired. The register port is control only, so there is no stream and no back-pressure.

Top module: `wdk_timer`

## Requirements
- R1: After rst_n is released, the control register reads 0 (disabled, active-low polarity, output gated, interrupt off), the length register reads 1023 in bits 14:5 (0x7FE0), status reads 0, the interval register reads 0, rst_out is 1 and irq_out is 0.
- R2: A write to the control register at byte offset 0x00 takes effect only when bits 31:24 equal 0x22. The fields are bit 0 enable, bit 1 polarity, bit 2 output enable, bit 3 interrupt enable and bit 6 dual (stored and read back, no effect). A read returns these fields at the same positions and 0 elsewhere.
- R3: A write to the length register at offset 0x04 takes effect only when bits 4:0 equal 0x08. The count is taken from bits 14:5, and a read returns the count in bits 14:5 and 0 elsewhere.
- R4: A control write that sets enable while the block is disabled loads the countdown. The reset pulse then starts exactly 512 × length clock cycles after that write edge, and the countdown reloads itself and keeps running.
- R5: Writing exactly 0x00001971 to offset 0x08 while enabled reloads the countdown, so the next expiry is 512 × length cycles after that write edge. Any other value is ignored.
- R6: Writing exactly 0x00001209 to offset 0x14 starts the reset pulse in the cycle after the write edge, whether or not the block is enabled. Any other value is ignored.
- R7: A keyed control write that clears enable stops the countdown: no expiry follows, and the interval register reads 0.
- R8: A length of 0 counts as one unit (512 cycles).
- R9: The pulse lasts 64 clock cycles. While the pulse is active and bit 2 is set, rst_out equals the polarity bit (1 means active high). Otherwise rst_out sits at the inverse of the polarity bit.
- R10: irq_out is 1 exactly while the pulse is active and bit 3 is set.
- R11: Status at offset 0x0C sets bit 31 on an expiry and bit 30 on a software reset. Both bits stay set until rst_n.
- R12: The interval register at offset 0x10 reads the remaining whole units of the countdown in bits 9:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Watchdog clock (32768 Hz in use) |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data, including its key field |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| rst_out | output | 1 | Reset pulse pin, polarity per control bit 1 |
| irq_out | output | 1 | Interrupt, high during the pulse when enabled |

## Verification
The bench times every pulse edge against a cycle predicted from the write edge. An off-by-one in the prescaler or the unit count, or an expiry that misses the reload, shows up as a pulse in the wrong cycle. Writes with a wrong key, a wrong restart value and a wrong reset value are mixed into live countdowns. A design that accepts any of them would reload early or fire a pulse the scoreboard does not expect. Length zero is run, and a design that does not clamp it would either never fire or wrap to a 1024-unit wait. The pulse is also fired with the output enable cleared and with each polarity, so a design that ignores the gate or inverts the level drives a visible assertion on the pin.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  localparam int unsigned ADDR_W = 5;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_LEN  = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_KICK = 5'h08;
  localparam logic [ADDR_W-1:0] OFS_STAT = 5'h0C;
  localparam logic [ADDR_W-1:0] OFS_IVAL = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_SWR  = 5'h14;

  localparam logic [7:0]        CTRL_KEY = 8'h22;
  localparam logic [4:0]        LEN_KEY  = 5'h08;
  localparam int unsigned       LEN_LSB  = 5;
  localparam logic [DATA_W-1:0] KICK_KEY = 32'h0000_1971;
  localparam logic [DATA_W-1:0] SWR_KEY  = 32'h0000_1209;

  typedef struct packed {
    logic dual;
    logic irq_en;
    logic out_en;
    logic pol;
    logic en;
  } ctrl_t;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CTRL, SEL_LEN, SEL_KICK, SEL_STAT, SEL_IVAL, SEL_SWR
  } sel_e;
endpackage

// File: rtl/wdk_regs.sv
module wdk_regs
  import wdk_pkg::*;
#(
  parameter int unsigned CNT_W   = 10,
  parameter int unsigned LEN_RST = 1023
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              we,
  input  logic [1:0]        cause,
  input  logic [CNT_W-1:0]  units,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  len,
  output logic              arm,
  output logic              kick,
  output logic              swr,
  output logic [DATA_W-1:0] rdata
);
  sel_e sel;
  logic ctrl_ok, len_ok;

  always_comb begin
    unique case (addr)
      OFS_CTRL: sel = SEL_CTRL;
      OFS_LEN:  sel = SEL_LEN;
      OFS_KICK: sel = SEL_KICK;
      OFS_STAT: sel = SEL_STAT;
      OFS_IVAL: sel = SEL_IVAL;
      OFS_SWR:  sel = SEL_SWR;
      default:  sel = SEL_NONE;
    endcase
  end

  assign ctrl_ok = we && (sel == SEL_CTRL) && (wdata[31:24] == CTRL_KEY);
  assign len_ok  = we && (sel == SEL_LEN) && (wdata[4:0] == LEN_KEY);
  assign arm     = ctrl_ok && wdata[0] && !ctrl.en;
  assign kick    = we && (sel == SEL_KICK) && (wdata == KICK_KEY);
  assign swr     = we && (sel == SEL_SWR) && (wdata == SWR_KEY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      len  <= CNT_W'(LEN_RST);
    end else begin
      if (ctrl_ok) begin
        ctrl.en     <= wdata[0];
        ctrl.pol    <= wdata[1];
        ctrl.out_en <= wdata[2];
        ctrl.irq_en <= wdata[3];
        ctrl.dual   <= wdata[6];
      end
      if (len_ok) len <= wdata[LEN_LSB +: CNT_W];
    end
  end

  always_comb begin
    rdata = '0;
    unique case (sel)
      SEL_CTRL: begin
        rdata[0] = ctrl.en;
        rdata[1] = ctrl.pol;
        rdata[2] = ctrl.out_en;
        rdata[3] = ctrl.irq_en;
        rdata[6] = ctrl.dual;
      end
      SEL_LEN:  rdata[LEN_LSB +: CNT_W] = len;
      SEL_STAT: begin
        rdata[31] = cause[1];
        rdata[30] = cause[0];
      end
      SEL_IVAL: rdata[CNT_W-1:0] = units;
      default:  rdata = '0;
    endcase
  end

  p_ctrl_badkey_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == OFS_CTRL && wdata[31:24] != CTRL_KEY) |=> $stable(ctrl));
  p_len_badkey_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == OFS_LEN && wdata[4:0] != LEN_KEY) |=> $stable(len));
endmodule

// File: rtl/wdk_countdown.sv
module wdk_countdown #(
  parameter int unsigned CNT_W    = 10,
  parameter int unsigned PRESCALE = 512
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             arm,
  input  logic             kick,
  input  logic [CNT_W-1:0] len,
  output logic [CNT_W-1:0] units,
  output logic             expire
);
  localparam int unsigned PS_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PS_W-1:0] PS_LAST = PS_W'(PRESCALE - 1);

  logic [PS_W-1:0]  presc;
  logic [CNT_W-1:0] len_eff;
  logic             presc_last, load;

  assign len_eff    = (len == '0) ? CNT_W'(1) : len;
  assign presc_last = (presc == PS_LAST);
  assign load       = arm || (en && kick);
  assign expire     = en && presc_last && (units == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc <= '0;
      units <= '0;
    end else if (load) begin
      presc <= '0;
      units <= len_eff;
    end else if (!en) begin
      presc <= '0;
      units <= '0;
    end else if (presc_last) begin
      presc <= '0;
      units <= (units == CNT_W'(1)) ? len_eff : units - CNT_W'(1);
    end else begin
      presc <= presc + PS_W'(1);
    end
  end

  p_load_nonzero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (units != '0) && (presc == '0));
  p_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !arm) |=> (units == '0));
  p_run_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !$past(arm)) |-> $past(en) ? (units != '0) : 1'b1);
  p_expire_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (presc == '0));
endmodule

// File: rtl/wdk_fire.sv
module wdk_fire #(
  parameter int unsigned PULSE_LEN = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       expire,
  input  logic       swr,
  output logic       active,
  output logic [1:0] cause
);
  localparam int unsigned PW = $clog2(PULSE_LEN + 1);

  logic [PW-1:0] cnt;
  logic          fire;

  assign fire   = expire || swr;
  assign active = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      cause <= '0;
    end else begin
      if (fire)        cnt <= PW'(PULSE_LEN);
      else if (active) cnt <= cnt - PW'(1);
      if (expire) cause[1] <= 1'b1;
      if (swr)    cause[0] <= 1'b1;
    end
  end

  p_pulse_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !fire) |=> (cnt == $past(cnt) - PW'(1)));
  p_sticky_tmo_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cause[1] |=> cause[1]);
  p_sticky_sw_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cause[0] |=> cause[0]);
endmodule

// File: rtl/wdk_timer.sv
module wdk_timer
  import wdk_pkg::*;
#(
  parameter int unsigned CNT_W     = 10,
  parameter int unsigned PRESCALE  = 512,
  parameter int unsigned PULSE_LEN = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              rst_out,
  output logic              irq_out
);
  localparam int unsigned LEN_RST = (1 << CNT_W) - 1;

  ctrl_t            ctrl;
  logic [CNT_W-1:0] len, units;
  logic [1:0]       cause;
  logic             arm, kick, swr, expire, active, drive;

  wdk_regs #(.CNT_W(CNT_W), .LEN_RST(LEN_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata), .we(bus_we),
    .cause(cause), .units(units), .ctrl(ctrl), .len(len),
    .arm(arm), .kick(kick), .swr(swr), .rdata(bus_rdata)
  );

  wdk_countdown #(.CNT_W(CNT_W), .PRESCALE(PRESCALE)) u_count (
    .clk(clk), .rst_n(rst_n), .en(ctrl.en), .arm(arm), .kick(kick),
    .len(len), .units(units), .expire(expire)
  );

  wdk_fire #(.PULSE_LEN(PULSE_LEN)) u_fire (
    .clk(clk), .rst_n(rst_n), .expire(expire), .swr(swr),
    .active(active), .cause(cause)
  );

  assign drive   = active && ctrl.out_en;
  assign rst_out = ctrl.pol ? drive : !drive;
  assign irq_out = active && ctrl.irq_en;

  p_irq_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (cause != 2'b00));
  p_pin_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_out == ctrl.pol) |-> (ctrl.out_en && cause != 2'b00));
endmodule

// File: tb/wdk_timer_tb.sv
module wdk_timer_tb;
  import wdk_pkg::*;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic              we = 1'b0;
  logic [DATA_W-1:0] rdata;
  logic              rst_out, irq_out;

  int      total = 0;
  int      bad = 0;
  longint  cyc = 0;
  logic    act_lvl = 1'b0;
  longint  exp_q[$];
  bit      done = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdk_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_wdata(wdata), .bus_we(we),
    .bus_rdata(rdata), .rst_out(rst_out), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic wait_to(input longint t);
    while (cyc < t) @(negedge clk);
  endtask

  // Monitor: pops the expected start cycle of every pulse seen on the pin
  initial begin
    bit     prev;
    bit     now;
    int     width;
    longint e;
    prev = 0; width = 0;
    forever begin
      @(negedge clk); #1;
      if (rst_n) begin
        now = (rst_out == act_lvl);
        if (now && !prev) begin
          total++;
          if (exp_q.size() == 0) begin
            bad++;
            $display("FAIL R4/R6: pulse at cycle %0d, expected none", cyc);
          end else begin
            e = exp_q.pop_front();
            if (e != cyc) begin
              bad++;
              $display("FAIL R4: pulse start actual=%0d expected=%0d", cyc, e);
            end
          end
          width = 0;
        end
        if (now) width++;
        if (!now && prev) begin
          total++;
          if (width != 64) begin
            bad++;
            $display("FAIL R9: pulse width actual=%0d expected=64", width);
          end
        end
        prev = now;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    longint w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(OFS_CTRL, v); check("R1 ctrl", v, 32'h0);
    rd(OFS_LEN, v);  check("R1 len", v, 32'h7FE0);
    rd(OFS_STAT, v); check("R1 status", v, 32'h0);
    rd(OFS_IVAL, v); check("R1 interval", v, 32'h0);
    check("R1 rst_out", {31'b0, rst_out}, 32'h1);
    check("R1 irq_out", {31'b0, irq_out}, 32'h0);

    // R2 wrong key ignored; R3 wrong key ignored
    wr(OFS_CTRL, 32'h2300_0005);
    rd(OFS_CTRL, v); check("R2 bad key", v, 32'h0);
    wr(OFS_LEN, (32'd5 << 5) | 32'h9);
    rd(OFS_LEN, v);  check("R3 bad key", v, 32'h7FE0);
    wr(OFS_LEN, (32'd2 << 5) | 32'h8);
    rd(OFS_LEN, v);  check("R3 good key", v, 32'h40);

    // Pin on, active high, still disabled
    wr(OFS_CTRL, 32'h2200_0006);
    act_lvl = 1'b1;
    check("R9 idle level", {31'b0, rst_out}, 32'h0);

    // R4 enable, then wrong restart value must not reload (R5)
    wr(OFS_CTRL, 32'h2200_0007);
    w = cyc;
    wait_to(w + 600);
    wr(OFS_KICK, 32'h0000_1972);
    rd(OFS_IVAL, v); check("R12 units left", v, 32'h1);
    exp_q.push_back(w + 1024);
    wait_to(w + 1024 + 80);

    // R5 good restart reloads the full length from the write edge
    wr(OFS_KICK, KICK_KEY);
    w = cyc;
    exp_q.push_back(w + 1024);
    wait_to(w + 1024 + 80);

    // R7 stop
    wr(OFS_CTRL, 32'h2200_0006);
    rd(OFS_IVAL, v); check("R7 interval stopped", v, 32'h0);
    wait_to(cyc + 1200);
    rd(OFS_STAT, v); check("R11 timeout cause", v, 32'h8000_0000);

    // R8 zero length with interrupt (R10)
    wr(OFS_LEN, 32'h8);
    rd(OFS_LEN, v); check("R8 len zero", v, 32'h0);
    wr(OFS_CTRL, 32'h2200_000F);
    w = cyc;
    exp_q.push_back(w + 512);
    wait_to(w + 512);
    #2 check("R10 irq during pulse", {31'b0, irq_out}, 32'h1);
    wait_to(w + 600);
    check("R10 irq after pulse", {31'b0, irq_out}, 32'h0);
    wr(OFS_CTRL, 32'h2200_0006);

    // R6 wrong value ignored, then software reset while disabled, active low
    wr(OFS_SWR, 32'h0000_1208);
    wait_to(cyc + 100);
    rd(OFS_STAT, v); check("R6 bad value", v, 32'h8000_0000);
    wr(OFS_CTRL, 32'h2200_0004);
    act_lvl = 1'b0;
    wr(OFS_SWR, SWR_KEY);
    w = cyc;
    exp_q.push_back(w);
    wait_to(w + 100);
    rd(OFS_STAT, v); check("R11 both causes", v, 32'hC000_0000);

    // R9 gated pin: pulse runs but the pin stays inactive
    wr(OFS_CTRL, 32'h2200_0000);
    wr(OFS_SWR, SWR_KEY);
    wait_to(cyc + 2);
    check("R9 gated pin", {31'b0, rst_out}, 32'h1);
    wait_to(cyc + 100);

    // R2 dual bit stored and read back only
    wr(OFS_CTRL, 32'h2200_0040);
    rd(OFS_CTRL, v); check("R2 dual readback", v, 32'h40);
    wait_to(cyc + 700);
    check("R4 queue drained", exp_q.size(), 32'h0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule